// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block maps addresses that fall inside a graphics aperture window onto physical memory pages. The first level of the lookup is a 64-entry directory held on chip. Software fills or clears that directory one slot at a time through a single packed register. Each directory slot names one second-level table page in memory, and that page holds 1024 entries. The block reads the second-level entry it needs over a simple memory read port. It then returns either a physical address or a fault.

Translations that succeed are kept in a small fully associative cache, so repeated accesses to the same aperture page need no memory read. The cache is emptied whenever any directory slot is written. Software can also empty it by writing control bit 7 low and then high again. The block accepts one request at a time and holds its request-ready output low while a second-level read is outstanding.

Top module: `aper_xlat`

## Requirements
- R1: After reset, req_ready_o is 1 and rsp_valid_o and mem_req_o are 0. Every directory slot is not present, the aperture base is 0 and the size code is 0.
- R2: A register write with reg_sel_i = 0 loads a directory slot. The write data is packed as follows: bits 5:0 give the slot index, bit 8 is the present flag, and bits 31:12 give the second-level page address. Bits 11:9 and 7:6 have no effect. The slot walk then reads the word at {page address, second-level index, 2'b00}.
- R3: A slot load with bit 8 clear makes that slot not present. Requests that reach that slot fault, and no memory read is made.
- R4: The slot index is request address bits 31:22 minus base bits 31:22. The second-level index is request address bits 21:12.
- R5: A second-level entry is valid when its bit 0 is 1. The response address is then entry bits 31:12 followed by request bits 11:0. When bit 0 is 0, the response is a fault with address 0.
- R6: reg_sel_i = 1 writes the size code from bits 5:0. The codes are: 0 for 65536 pages, 32 for 32768, 48 for 16384, 56 for 8192, and 0 pages for any other code. reg_sel_i = 3 writes the base from bits 31:22. A request below the base, or whose page offset from the base is at least the page count, faults without a memory read.
- R7: Only one memory read is outstanding at a time. mem_req_o and mem_addr_o hold until mem_valid_i. req_ready_o is 0 during the walk. The response comes one cycle after mem_valid_i. A fault or a cache hit responds one cycle after acceptance.
- R8: Successful translations fill a 4-entry fully associative cache, keyed on the aperture page offset and replaced in round-robin order. A hit makes no memory read.
- R9: A write with reg_sel_i = 2 empties the cache only when bit 7 goes from 0 to 1. Writing bit 7 as 0, or writing 1 while it is already 1, leaves the cache intact.
- R10: Any directory slot write empties the cache and restarts the replacement order at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 directory, 1 size, 2 control, 3 base |
| reg_wdata_i | input | 32 | Register write data |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | 32 | Aperture address to translate |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_fault_o | output | 1 | Response is a fault |
| rsp_paddr_o | output | 32 | Translated physical address |
| mem_req_o | output | 1 | Second-level read request |
| mem_addr_o | output | 32 | Byte address of the second-level entry |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Second-level entry read back |

## Verification
The bench tries the exact edges of every size code: the last page in range and the first page out of range. A wrong size decode would walk memory for a page that should fault, or fault a page that is legal. It fills five distinct pages and checks that the first is the one evicted. A non-round-robin cache would miss on the wrong page.

It changes the memory contents behind a cached page to tell a stale hit apart from a fresh walk. This shows that only a 0-to-1 change of control bit 7 flushes the cache, and that a directory write does too. It also checks that clearing a slot stops walks through it. Random traffic across and below the window compares every response with a model built from the requirements.

// File: rtl/aper_pkg.sv
package aper_pkg;
  localparam int AW     = 32;
  localparam int PG_SH  = 12;
  localparam int DIR_SH = 22;
  localparam int DIR_W  = 6;
  localparam int DIR_N  = 1 << DIR_W;
  localparam int L2_W   = DIR_SH - PG_SH;
  localparam int PN_W   = DIR_W + L2_W;
  localparam int PNF_W  = AW - PG_SH;
  localparam int FR_W   = AW - PG_SH;
  localparam int HI_W   = AW - DIR_SH;
  localparam int SZ_W   = 6;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_SIZE = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_BASE = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } walk_st_e;

  function automatic logic [PN_W:0] size_pages(input logic [SZ_W-1:0] code);
    logic [PN_W:0] full;
    full = {1'b1, {PN_W{1'b0}}};
    case (code)
      6'd0:    return full;
      6'd32:   return full >> 1;
      6'd48:   return full >> 2;
      6'd56:   return full >> 3;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/aper_cfg.sv
module aper_cfg
  import aper_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [AW-1:0]    wdata_i,
  input  logic [DIR_W-1:0] rd_idx_i,
  output logic             rd_pres_o,
  output logic [FR_W-1:0]  rd_pa_o,
  output logic [PN_W:0]    pages_o,
  output logic [HI_W-1:0]  base_hi_o,
  output logic             clr_o
);
  logic [DIR_N-1:0]  pres_q;
  logic [FR_W-1:0]   pa_q [DIR_N];
  logic [SZ_W-1:0]   size_q;
  logic [HI_W-1:0]   base_q;
  logic              ctl7_q;
  logic              dir_we;
  logic              ctl_we;
  logic [DIR_W-1:0]  wr_idx;

  assign dir_we = we_i && (sel_i == SEL_DIR);
  assign ctl_we = we_i && (sel_i == SEL_CTRL);
  assign wr_idx = wdata_i[DIR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pres_q <= '0;
      size_q <= '0;
      base_q <= '0;
      ctl7_q <= 1'b0;
    end else begin
      if (dir_we) pres_q[wr_idx] <= wdata_i[8];
      if (we_i && sel_i == SEL_SIZE) size_q <= wdata_i[SZ_W-1:0];
      if (we_i && sel_i == SEL_BASE) base_q <= wdata_i[AW-1:DIR_SH];
      if (ctl_we) ctl7_q <= wdata_i[7];
    end
  end

  // page addresses need no reset: guarded by present bits
  always_ff @(posedge clk_i) begin
    if (dir_we) pa_q[wr_idx] <= wdata_i[AW-1:PG_SH];
  end

  assign rd_pres_o = pres_q[rd_idx_i];
  assign rd_pa_o   = pa_q[rd_idx_i];
  assign pages_o   = size_pages(size_q);
  assign base_hi_o = base_q;
  // flush on directory write or control bit 7 rising
  assign clr_o     = dir_we || (ctl_we && wdata_i[7] && !ctl7_q);

  // R3: a slot load with present clear leaves that slot absent
  a_r3_slot_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we && !wdata_i[8] |=> !pres_q[$past(wr_idx)]);

  // R2: a slot load with present set marks that slot present
  a_r2_slot_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we && wdata_i[8] |=> pres_q[$past(wr_idx)]);
endmodule

// File: rtl/aper_tcache.sv
module aper_tcache
  import aper_pkg::*;
#(
  parameter int N = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [PN_W-1:0] lk_tag_i,
  output logic            hit_o,
  output logic [FR_W-1:0] hit_fr_o,
  input  logic            fill_i,
  input  logic [PN_W-1:0] fill_tag_i,
  input  logic [FR_W-1:0] fill_fr_i
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]    vld_q;
  logic [PN_W-1:0] tag_q [N];
  logic [FR_W-1:0] fr_q  [N];
  logic [PW-1:0]   ptr_q;
  logic [N-1:0]    hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_match
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag_i);
  end

  always_comb begin
    hit_fr_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_fr_o = hit_fr_o | fr_q[i];
    end
  end
  assign hit_o = |hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ptr_q <= '0;
      for (int i = 0; i < N; i++) begin
        tag_q[i] <= '0;
        fr_q[i]  <= '0;
      end
    end else if (clr_i) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (fill_i) begin
      vld_q[ptr_q] <= 1'b1;
      tag_q[ptr_q] <= fill_tag_i;
      fr_q[ptr_q]  <= fill_fr_i;
      ptr_q        <= (ptr_q == PW'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  // R8: one page lives in at most one slot
  a_r8_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  // R10: a clear empties every slot
  a_r10_cache_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (vld_q == '0));
endmodule

// File: rtl/aper_walk.sv
module aper_walk
  import aper_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_addr_i,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [AW-1:0]    rsp_paddr_o,
  input  logic [HI_W-1:0]  base_hi_i,
  input  logic [PN_W:0]    pages_i,
  output logic [DIR_W-1:0] dir_idx_o,
  input  logic             dir_pres_i,
  input  logic [FR_W-1:0]  dir_pa_i,
  output logic [PN_W-1:0]  lk_tag_o,
  input  logic             hit_i,
  input  logic [FR_W-1:0]  hit_fr_i,
  input  logic             clr_i,
  output logic             fill_o,
  output logic [PN_W-1:0]  fill_tag_o,
  output logic [FR_W-1:0]  fill_fr_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_valid_i,
  input  logic [AW-1:0]    mem_rdata_i
);
  walk_st_e          st_q;
  logic [AW-1:0]     base_addr;
  logic [AW-1:0]     off;
  logic [PNF_W-1:0]  pn;
  logic              oob;
  logic              accept;
  logic [AW-1:0]     maddr_q;
  logic [PN_W-1:0]   tag_q;
  logic [PG_SH-1:0]  ofs_q;
  logic              kill_q;
  logic              rsp_v_q;
  logic              rsp_f_q;
  logic [AW-1:0]     rsp_pa_q;

  assign base_addr = {base_hi_i, {DIR_SH{1'b0}}};
  assign off       = req_addr_i - base_addr;
  assign pn        = off[AW-1:PG_SH];
  assign oob       = (req_addr_i < base_addr) || (pn >= PNF_W'(pages_i));
  assign dir_idx_o = pn[PN_W-1:L2_W];
  assign lk_tag_o  = pn[PN_W-1:0];
  assign accept    = req_valid_i && (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      maddr_q  <= '0;
      tag_q    <= '0;
      ofs_q    <= '0;
      kill_q   <= 1'b0;
      rsp_v_q  <= 1'b0;
      rsp_f_q  <= 1'b0;
      rsp_pa_q <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            if (oob || !dir_pres_i) begin
              rsp_v_q  <= 1'b1;
              rsp_f_q  <= 1'b1;
              rsp_pa_q <= '0;
            end else if (hit_i) begin
              rsp_v_q  <= 1'b1;
              rsp_f_q  <= 1'b0;
              rsp_pa_q <= {hit_fr_i, req_addr_i[PG_SH-1:0]};
            end else begin
              st_q    <= ST_WAIT;
              maddr_q <= {dir_pa_i, pn[L2_W-1:0], 2'b00};
              tag_q   <= pn[PN_W-1:0];
              ofs_q   <= req_addr_i[PG_SH-1:0];
              kill_q  <= clr_i;
            end
          end
        end
        ST_WAIT: begin
          if (clr_i) kill_q <= 1'b1;
          if (mem_valid_i) begin
            rsp_v_q  <= 1'b1;
            rsp_f_q  <= !mem_rdata_i[0];
            rsp_pa_q <= mem_rdata_i[0] ? {mem_rdata_i[AW-1:PG_SH], ofs_q} : '0;
            st_q     <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // a flush racing the walk must not leave a stale fill behind
  assign fill_o      = (st_q == ST_WAIT) && mem_valid_i && mem_rdata_i[0] && !kill_q && !clr_i;
  assign fill_tag_o  = tag_q;
  assign fill_fr_o   = mem_rdata_i[AW-1:PG_SH];
  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_WAIT);
  assign mem_addr_o  = maddr_q;
  assign rsp_valid_o = rsp_v_q;
  assign rsp_fault_o = rsp_f_q;
  assign rsp_paddr_o = rsp_pa_q;

  // R7: request and address hold until data returns
  a_r7_read_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));

  // R7: response follows read data by one cycle, walk ends
  a_r7_rsp_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_valid_i |=> rsp_valid_o && !mem_req_o);

  // R5: invalid second-level entry yields a fault
  a_r5_entry_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_valid_i && !mem_rdata_i[0] |=> rsp_fault_o);

  // R6: out-of-window request faults with no walk
  a_r6_oob_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && oob |=> rsp_valid_o && rsp_fault_o && !mem_req_o);

  // R3: absent slot faults with no walk
  a_r3_absent_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !dir_pres_i |=> rsp_valid_o && rsp_fault_o && !mem_req_o);
endmodule

// File: rtl/aper_xlat.sv
module aper_xlat
  import aper_pkg::*;
#(
  parameter int CACHE_N = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_addr_i,
  output logic        rsp_valid_o,
  output logic        rsp_fault_o,
  output logic [31:0] rsp_paddr_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_valid_i,
  input  logic [31:0] mem_rdata_i
);
  logic [DIR_W-1:0] dir_idx;
  logic             dir_pres;
  logic [FR_W-1:0]  dir_pa;
  logic [PN_W:0]    pages;
  logic [HI_W-1:0]  base_hi;
  logic             clr;
  logic [PN_W-1:0]  lk_tag;
  logic             hit;
  logic [FR_W-1:0]  hit_fr;
  logic             fill;
  logic [PN_W-1:0]  fill_tag;
  logic [FR_W-1:0]  fill_fr;

  aper_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .rd_idx_i  (dir_idx),
    .rd_pres_o (dir_pres),
    .rd_pa_o   (dir_pa),
    .pages_o   (pages),
    .base_hi_o (base_hi),
    .clr_o     (clr)
  );

  aper_tcache #(.N(CACHE_N)) u_cache (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .lk_tag_i   (lk_tag),
    .hit_o      (hit),
    .hit_fr_o   (hit_fr),
    .fill_i     (fill),
    .fill_tag_i (fill_tag),
    .fill_fr_i  (fill_fr)
  );

  aper_walk u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_fault_o (rsp_fault_o),
    .rsp_paddr_o (rsp_paddr_o),
    .base_hi_i   (base_hi),
    .pages_i     (pages),
    .dir_idx_o   (dir_idx),
    .dir_pres_i  (dir_pres),
    .dir_pa_i    (dir_pa),
    .lk_tag_o    (lk_tag),
    .hit_i       (hit),
    .hit_fr_i    (hit_fr),
    .clr_i       (clr),
    .fill_o      (fill),
    .fill_tag_o  (fill_tag),
    .fill_fr_o   (fill_fr),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .mem_rdata_i (mem_rdata_i)
  );

  // R7: no new request is taken while a read is out
  a_r7_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
endmodule

// File: tb/sim_aper_xlat.sv
module sim_aper_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int nchk = 0, nerr = 0;
  int reads = 0, mwait = 0, mlat = 1, epoch = 0;
  logic [31:0] last_maddr = '0;
  logic        ready_in_walk = 1'b1;

  bit          dpres [64];
  logic [19:0] dpa   [64];
  logic [9:0]  b_hi = '0;
  logic [5:0]  szc = '0;

  always #5 clk = ~clk;

  aper_xlat u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault),
    .rsp_paddr_o(rsp_paddr), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] l2_ent(input logic [31:0] ma, input int ep);
    logic [31:0] h;
    h = (ma ^ (32'(ep) * 32'h5bd1e995)) * 32'h9e3779b1;
    h = h ^ (h >> 15);
    if (h[3:0] == 4'h0) return 32'h0;
    if (h[3:0] == 4'h1) return {h[31:12], 12'h0};
    return {h[31:12], 11'h0, 1'b1};
  endfunction

  function automatic logic [16:0] pages_of(input logic [5:0] c);
    case (c)
      6'd0:    return 17'd65536;
      6'd32:   return 17'd32768;
      6'd48:   return 17'd16384;
      6'd56:   return 17'd8192;
      default: return 17'd0;
    endcase
  endfunction

  // {fault, paddr}
  function automatic logic [32:0] exp_x(input logic [31:0] a, input int ep);
    logic [31:0] base, off, e;
    logic [19:0] pn;
    logic [5:0]  di;
    base = {b_hi, 22'h0};
    if (a < base) return {1'b1, 32'h0};
    off = a - base;
    pn  = off[31:12];
    if (pn >= 20'(pages_of(szc))) return {1'b1, 32'h0};
    di = pn[15:10];
    if (!dpres[di]) return {1'b1, 32'h0};
    e = l2_ent({dpa[di], pn[9:0], 2'b00}, ep);
    if (!e[0]) return {1'b1, 32'h0};
    return {1'b0, e[31:12], a[11:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory model with random latency
  always @(negedge clk) begin
    if (mem_req && !mem_valid) begin
      if (mwait >= mlat) begin
        mem_valid  = 1'b1;
        mem_rdata  = l2_ent(mem_addr, epoch);
        last_maddr = mem_addr;
        reads++;
        mwait = 0;
        mlat = int'($urandom % 4);
      end else mwait++;
    end else begin
      mem_valid = 1'b0;
    end
  end

  task automatic reg_wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic load_dir(input int i, input bit p, input logic [19:0] pa);
    dpres[i] = p;
    if (p) dpa[i] = pa;
    // reserved and attribute bits set to show they are ignored
    reg_wr(2'd0, {pa, 3'b101, p, 2'b11, 6'(i)} & (p ? 32'hffff_ffff : 32'h0000_0eff));
  endtask

  task automatic xlate(input logic [31:0] a, output logic f, output logic [31:0] p,
                       output int lat, output int rd);
    int r0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = reads;
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    ready_in_walk = 1'b0;
    while (!rsp_valid && lat < 60) begin
      if (lat == 1) ready_in_walk = req_ready;
      @(negedge clk);
      lat++;
    end
    f = rsp_fault; p = rsp_paddr; rd = reads - r0;
  endtask

  task automatic xcheck(input logic [31:0] a, input string tag);
    logic f; logic [31:0] p; int lat, rd; logic [32:0] e;
    xlate(a, f, p, lat, rd);
    e = exp_x(a, epoch);
    chk({f, p} == e, tag, {31'h0, f, p}, {31'h0, e});
  endtask

  initial begin : wdog
    #1500000;
    nerr++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin : main
    logic f; logic [31:0] p; int lat, rd;
    logic [32:0] e, old;
    logic [31:0] base, pg [5];
    int np;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) begin dpres[i] = 0; dpa[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !mem_req, "R1 reset outputs",
        {61'h0, req_ready, rsp_valid, mem_req}, 64'h4);
    xlate(32'h0000_1000, f, p, lat, rd);
    chk(f && rd == 0 && lat == 1, "R1 empty directory faults",
        {f, 31'(rd), 32'(lat)}, {1'b1, 31'h0, 32'h1});

    // R6 base register, R2 load
    base = 32'h4000_0000;
    b_hi = base[31:22];
    reg_wr(2'd3, base | 32'h0003_ffff);
    load_dir(0, 1, 20'h12345);
    xlate(base + 32'h5abc, f, p, lat, rd);
    chk(rd == 1 && last_maddr == {20'h12345, 10'd5, 2'b00}, "R2 walk address",
        {32'(rd), last_maddr}, {32'h1, 20'h12345, 10'd5, 2'b00});
    chk(!ready_in_walk, "R7 ready low during walk", {63'h0, ready_in_walk}, 64'h0);
    e = exp_x(base + 32'h5abc, epoch);
    chk({f, p} == e, "R5 translated value", {31'h0, f, p}, {31'h0, e});
    xlate(base + 32'h5123, f, p, lat, rd);
    chk(rd == 0 && lat == 1, "R8 hit makes no read", {32'(rd), 32'(lat)}, {32'h0, 32'h1});

    // R4 slot index from base
    load_dir(3, 1, 20'habcde);
    xlate(base + 32'h00c0_0000 + 32'h003f_f000, f, p, lat, rd);
    chk(rd == 1 && last_maddr == {20'habcde, 10'h3ff, 2'b00}, "R4 slot and index",
        {32'(rd), last_maddr}, {32'h1, 20'habcde, 10'h3ff, 2'b00});
    // R3 clear slot
    load_dir(3, 0, 20'h0);
    xlate(base + 32'h00c0_0000 + 32'h003f_f000, f, p, lat, rd);
    chk(f && rd == 0, "R3 cleared slot faults", {f, 31'(rd)}, {1'b1, 31'h0});
    // R10 directory write flushed page cached earlier
    xlate(base + 32'h5abc, f, p, lat, rd);
    chk(rd == 1, "R10 directory write flushes cache", 64'(rd), 64'h1);

    // populate all slots
    for (int i = 0; i < 64; i++) load_dir(i, 1, 20'($urandom));
    // R6 size edges
    for (int k = 0; k < 4; k++) begin
      logic [5:0] c;
      logic [31:0] lastin;
      c = (k == 0) ? 6'd56 : (k == 1) ? 6'd48 : (k == 2) ? 6'd32 : 6'd0;
      szc = c;
      reg_wr(2'd1, {26'h0, c});
      lastin = base + ((32'(pages_of(c)) - 1) << 12) + 32'h0fc;
      xcheck(lastin, "R6 last page in range");
      xlate(lastin + 32'h1000, f, p, lat, rd);
      chk(f && rd == 0, "R6 first page out of range", {f, 31'(rd)}, {1'b1, 31'h0});
    end
    xlate(base - 32'h1000, f, p, lat, rd);
    chk(f && rd == 0 && lat == 1, "R6 below base faults", {f, 31'(rd)}, {1'b1, 31'h0});
    szc = 6'd5;
    reg_wr(2'd1, 32'd5);
    xlate(base, f, p, lat, rd);
    chk(f && rd == 0, "R6 unknown size code", {f, 31'(rd)}, {1'b1, 31'h0});
    szc = 6'd0;
    reg_wr(2'd1, 32'd0);

    // R8 round robin: fresh cache
    load_dir(0, 1, 20'h0777);
    np = 0;
    for (int k = 0; k < 200 && np < 5; k++) begin
      e = exp_x(base + 32'(k) * 32'h1000, epoch);
      if (!e[32]) begin pg[np] = base + 32'(k) * 32'h1000; np++; end
    end
    for (int i = 0; i < 5; i++) xcheck(pg[i], "R8 fill value");
    for (int i = 1; i < 5; i++) begin
      xlate(pg[i], f, p, lat, rd);
      chk(rd == 0, "R8 recent page hits", 64'(rd), 64'h0);
    end
    xlate(pg[0], f, p, lat, rd);
    chk(rd == 1, "R8 oldest page evicted", 64'(rd), 64'h1);

    // R9 flush sequence, memory contents change under cache
    old = exp_x(pg[2], epoch);
    epoch = 1;
    xlate(pg[2], f, p, lat, rd);
    chk({f, p} == old && rd == 0, "R9 stale hit before flush", {31'h0, f, p}, {31'h0, old});
    reg_wr(2'd2, 32'h2200);
    xlate(pg[2], f, p, lat, rd);
    chk(rd == 0, "R9 bit7 low alone keeps cache", 64'(rd), 64'h0);
    reg_wr(2'd2, 32'h2280);
    xlate(pg[2], f, p, lat, rd);
    e = exp_x(pg[2], epoch);
    chk(rd == 1 && {f, p} == e, "R9 rising bit7 flushes", {31'h0, f, p}, {31'h0, e});
    if (!e[32]) begin
      reg_wr(2'd2, 32'h2280);
      xlate(pg[2], f, p, lat, rd);
      chk(rd == 0, "R9 bit7 held high keeps cache", 64'(rd), 64'h0);
    end

    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      if (n % 100 == 50) begin
        logic [5:0] c;
        c = ($urandom % 2) ? 6'd48 : 6'd0;
        szc = c;
        reg_wr(2'd1, {26'h0, c});
      end
      if (n % 37 == 0) load_dir(int'($urandom % 64), ($urandom % 4) != 0, 20'($urandom));
      if (n % 3 == 0) a = base + ($urandom % 32'h0004_0000);
      else a = 32'h3f00_0000 + ($urandom % 32'h1200_0000);
      xcheck(a, "R5 random translation");
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule